// File: doc/BRIEF.md
# Adaptive Rotating Serializer/Deserializer

This block carries an N-bit message between a sending half and a receiving half when repair has left fewer usable lanes than message bits. The sender captures the message into a rotating register and puts the low `mshift` bits of that register on the lanes each cycle. The receiver drops each arriving slice into the top `mshift` bits of its own register while shifting the older contents down. Because slices arrive at the top and move down, the message is already in place when the last slice lands. No extra alignment cycle is needed, and the transfer takes ceil(N/mshift) cycles.

When N is not a multiple of `mshift`, the sender uses a shorter rotation, by N mod `mshift`, to prepare the last slice. The last slice then overlaps the one before it by a few bits. The receiver makes the same shorter shift when that slice arrives, so the bits that are sent twice land on top of themselves.

The lane count is a static configuration input that comes from the repair logic. The lanes are modelled as ideal wires between the two halves. The sender's busy flag also serves as the slice strobe for the receiver.

Top module: `arsd_link`

## Requirements
- R1: While reset is asserted, and after its release until a message is accepted, `busy`, `rx_valid` and every bit of `lanes` are 0.
- R2: A message is accepted on a clock edge where `tx_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly K = ceil(N/me) consecutive cycles, where me = min(max(`mshift`,1), N).
- R3: `tx_valid` is ignored while `busy` is 1. The message in flight is delivered unchanged, and no second transfer starts after it.
- R4: In the first busy cycle, `lanes[me-1:0]` carries `tx_data[me-1:0]`. Lane bits at positions me and above are 0 in every cycle, and all lanes are 0 when `busy` is 0.
- R5: Busy cycle j (counting from 0), for 0 < j < K-1, carries message bits j*me to j*me+me-1 on `lanes[me-1:0]`. This is a right rotation of me between slices.
- R6: When K > 1, the last busy cycle carries message bits N-me to N-1 on `lanes[me-1:0]`. This is the result of a final rotation by N mod me, or by me when me divides N.
- R7: When `mshift` >= N, the whole message is sent in a single busy cycle with `lanes` equal to `tx_data`.
- R8: In the cycle right after the last busy cycle, `rx_valid` is 1 for one cycle and `rx_data` equals the accepted message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mshift | input | CFG_W | Number of usable lanes (static configuration) |
| tx_valid | input | 1 | Message offered for transmission |
| tx_data | input | N_BITS | Message to send |
| busy | output | 1 | Sender is transferring slices; also the slice strobe |
| lanes | output | N_BITS | Lane bits; only the low me positions are used |
| rx_valid | output | 1 | One-cycle strobe for a reassembled message |
| rx_data | output | N_BITS | Reassembled message |

## Verification
The assertions take `mshift` as a configuration value that is never zero and does not change while `busy` is high. They also rely on the receiver seeing exactly the slices that the sender produces. The stimulus respects these assumptions: the bench changes `mshift` only on an idle cycle, before it offers a message, and it sweeps every value from 1 to N+1. The case N+1 exercises the clamped single-cycle path. For every `mshift`, the bench sends all 2^N messages. On some of them it holds `tx_valid` high for the whole transfer with different data, to show that the extra offers are ignored.

// File: rtl/arsd_pkg.sv
package arsd_pkg;

  // ceil(a/b) for positive operands
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // size of the closing step: the remainder, or a full step when exact
  function automatic int tail_amount(input int a, input int b);
    int rem;
    rem = a % b;
    return (rem == 0) ? b : rem;
  endfunction

endpackage

// File: rtl/arsd_cfg.sv
module arsd_cfg #(
  parameter int N     = 8,
  parameter int CFG_W = 4,
  parameter int CW    = 4
) (
  input  logic [CFG_W-1:0] mshift,
  output logic [CW-1:0]    m_eff,
  output logic [CW-1:0]    n_slices,
  output logic [CW-1:0]    last_amt,
  output logic [N-1:0]     lane_mask
);

  always_comb begin
    int mi;
    mi = int'(mshift);
    if (mi < 1) mi = 1;
    if (mi > N) mi = N;
    m_eff    = CW'(mi);
    n_slices = CW'(arsd_pkg::ceil_div(N, mi));
    last_amt = CW'(arsd_pkg::tail_amount(N, mi));
    for (int i = 0; i < N; i++) begin
      lane_mask[i] = (i < mi);
    end
  end

endmodule

// File: rtl/arsd_tx.sv
module arsd_tx #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_valid,
  input  logic [N-1:0]  tx_data,
  input  logic [CW-1:0] m_eff,
  input  logic [CW-1:0] n_slices,
  input  logic [CW-1:0] last_amt,
  input  logic [N-1:0]  lane_mask,
  output logic          busy,
  output logic [N-1:0]  lanes
);

  logic [N-1:0]   sr_q, sr_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           busy_q, busy_d;
  logic           sr_en;
  logic           accept;
  logic [CW-1:0]  amt;
  logic [2*N-1:0] dbl;

  assign accept = tx_valid & ~busy_q;
  assign sr_en  = accept | busy_q;

  // next-state
  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    amt    = m_eff;
    dbl    = '0;
    if (accept) begin
      sr_d   = tx_data;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (int'(cnt_q) + 2 == int'(n_slices)) amt = last_amt;
      dbl   = {sr_q, sr_q} >> amt;
      sr_d  = dbl[N-1:0];
      cnt_d = cnt_q + 1'b1;
      if (int'(cnt_q) + 1 == int'(n_slices)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (sr_en) begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy  = busy_q;
  assign lanes = busy_q ? (sr_q & lane_mask) : '0;

  AST_SLICE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) < int'(n_slices))); // R2

endmodule

// File: rtl/arsd_rx.sv
module arsd_rx #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [N-1:0]  lanes,
  input  logic [CW-1:0] m_eff,
  input  logic [CW-1:0] n_slices,
  input  logic [CW-1:0] last_amt,
  input  logic [N-1:0]  lane_mask,
  output logic          rx_valid,
  output logic [N-1:0]  rx_data
);

  logic [N-1:0]  dr_q, dr_d;
  logic [CW-1:0] rcnt_q, rcnt_d;
  logic          vld_q, vld_d;
  logic          last;
  logic [CW-1:0] sh;
  logic [N-1:0]  top_mask;

  assign last     = (int'(rcnt_q) + 1 == int'(n_slices));
  assign top_mask = lane_mask << (N - int'(m_eff));

  // next-state
  always_comb begin
    dr_d   = dr_q;
    rcnt_d = rcnt_q;
    vld_d  = 1'b0;
    sh     = last ? last_amt : m_eff;
    if (strobe) begin
      dr_d   = ((dr_q >> sh) & ~top_mask) | (lanes << (N - int'(m_eff)));
      rcnt_d = last ? '0 : rcnt_q + 1'b1;
      vld_d  = last;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= '0;
      rcnt_q <= '0;
    end else if (strobe) begin
      dr_q   <= dr_d;
      rcnt_q <= rcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign rx_valid = vld_q;
  assign rx_data  = dr_q;

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R8
  AST_RX_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (rcnt_q == '0)); // R8

endmodule

// File: rtl/arsd_link.sv
module arsd_link #(
  parameter int N_BITS = 8,
  parameter int CFG_W  = $clog2(N_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  mshift,
  input  logic              tx_valid,
  input  logic [N_BITS-1:0] tx_data,
  output logic              busy,
  output logic [N_BITS-1:0] lanes,
  output logic              rx_valid,
  output logic [N_BITS-1:0] rx_data
);

  localparam int CW = $clog2(N_BITS + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CW-1:0]     m_eff, n_slices, last_amt;
  logic [N_BITS-1:0] lane_mask;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  arsd_cfg #(.N(N_BITS), .CFG_W(CFG_W), .CW(CW)) u_cfg (
    .mshift    (mshift),
    .m_eff     (m_eff),
    .n_slices  (n_slices),
    .last_amt  (last_amt),
    .lane_mask (lane_mask)
  );

  arsd_tx #(.N(N_BITS), .CW(CW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .m_eff     (m_eff),
    .n_slices  (n_slices),
    .last_amt  (last_amt),
    .lane_mask (lane_mask),
    .busy      (busy),
    .lanes     (lanes)
  );

  arsd_rx #(.N(N_BITS), .CW(CW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .strobe    (busy),
    .lanes     (lanes),
    .m_eff     (m_eff),
    .n_slices  (n_slices),
    .last_amt  (last_amt),
    .lane_mask (lane_mask),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data)
  );

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> $stable(mshift)); // R2
  AST_CFG_NONZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> (mshift != '0)); // R2
  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> $past(tx_valid)); // R2
  AST_RX_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_valid |-> ($past(busy) && !busy)); // R8

endmodule

// File: tb/sim_arsd_link.sv
module sim_arsd_link;

  localparam int N  = 8;
  localparam int CF = $clog2(N + 2);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CF-1:0] mshift;
  logic          tx_valid;
  logic [N-1:0]  tx_data;
  logic          busy;
  logic [N-1:0]  lanes;
  logic          rx_valid;
  logic [N-1:0]  rx_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  arsd_link #(.N_BITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .mshift(mshift), .tx_valid(tx_valid),
    .tx_data(tx_data), .busy(busy), .lanes(lanes),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_slice(input int msg, input int m, input int j);
    int me, k, start;
    me    = (m > N) ? N : m;
    k     = (N + me - 1) / me;
    start = (k > 1 && j == k - 1) ? (N - me) : j * me;
    return (msg >> start) & ((1 << me) - 1);
  endfunction

  task automatic send(input int msg, input int m, input bit poke);
    int me, k;
    string tag;
    me = (m > N) ? N : m;
    k  = (N + me - 1) / me;
    @(negedge clk);
    mshift   = CF'(m);
    tx_valid = 1'b1;
    tx_data  = N'(msg);
    @(negedge clk);
    tx_valid = poke;
    tx_data  = ~N'(msg);
    for (int j = 0; j < k; j++) begin
      if (k == 1)          tag = "R7";
      else if (j == 0)     tag = "R4";
      else if (j == k - 1) tag = "R6";
      else                 tag = "R5";
      chk(busy === 1'b1, "R2", int'(busy), 1);
      chk(lanes === N'(exp_slice(msg, m, j)), tag, int'(lanes), exp_slice(msg, m, j));
      chk(rx_valid === 1'b0, "R8", int'(rx_valid), 0);
      if (j == k - 1) tx_valid = 1'b0;
      @(negedge clk);
    end
    chk(busy === 1'b0, poke ? "R3" : "R2", int'(busy), 0);
    chk(rx_valid === 1'b1, "R8", int'(rx_valid), 1);
    chk(rx_data === N'(msg), poke ? "R3" : "R8", int'(rx_data), msg);
    chk(lanes === '0, "R4", int'(lanes), 0);
    @(negedge clk);
    chk(rx_valid === 1'b0, "R8", int'(rx_valid), 0);
    chk(busy === 1'b0, poke ? "R3" : "R2", int'(busy), 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    mshift   = CF'(1);
    tx_valid = 1'b0;
    tx_data  = '0;
    repeat (3) begin
      @(negedge clk);
      chk(busy === 1'b0 && rx_valid === 1'b0 && lanes === '0, "R1",
          int'({busy, rx_valid}), 0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(busy === 1'b0 && rx_valid === 1'b0 && lanes === '0, "R1",
          int'({busy, rx_valid}), 0);
    end
    for (int m = 1; m <= N + 1; m++) begin
      for (int msg = 0; msg < (1 << N); msg++) begin
        send(msg, m, ((msg % 3) == 1));
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule